// File: doc/BRIEF.md
# Memory Range Decoder Commit Bank

This block holds the programming of a small set of memory-range decoders behind a 32-bit word-addressed register port. Each decoder has a 64-bit base, a 64-bit size, a control word and one more 64-bit register. For an endpoint-type bank that register is the skip amount. For a switch-type bank it is a target list of eight 8-bit port IDs, with way k in bits 8k+7:8k. Software writes the registers and then sets the commit request bit. The decoder does not take the new values as live until a commit engine has checked them.

After a fixed delay of `COMMIT_LAT` clock cycles, each commit ends with either a committed flag or a commit-error flag. The checks are:
- the size is nonzero;
- the interleave ways and granularity encodings are supported by the capability word;
- for an endpoint bank, the size divides evenly by the way count;
- for decoder i > 0, decoder i-1 is already committed (strict index order).

Clearing the commit request bit decommits the decoder. A committed decoder that also has its lock bit set ignores all writes until reset. A read-only capability word describes the bank.

Top module: `mem_decoder_bank`

## Requirements
- R1: Synchronous active-high reset clears every decoder: base, size, the extra register and the control word read as zero, and both status outputs are zero.
- R2: Word address 0 is the capability word. Decoder i occupies word addresses 8+8i to 8+8i+6, at these offsets: 0 base[31:0], 1 base[63:32], 2 size[31:0], 3 size[63:32], 4 control, 5 extra[31:0], 6 extra[63:32]. A read with `rd_en` high returns its data on `rdata` after the next rising edge. Unmapped words read as zero.
- R3: The capability word has this layout:
  - [3:0] decoder count;
  - [7:4] target count;
  - bit 8: interleave on address bits 11:8;
  - bit 9: interleave on address bits 14:12;
  - bit 10: 3/6/12-way support;
  - bit 11: 16-way support.
- R4: The control word has this layout:
  - [3:0] granularity code;
  - [7:4] ways code;
  - bit 8: lock;
  - bit 9: commit request;
  - bit 10: committed (read-only);
  - bit 11: commit error (read-only);
  - bit 12: host-only.

  When a write sets commit request from 0 to 1, exactly one of committed or error rises on the `COMMIT_LAT`-th rising edge after the write edge, and not before.
- R5: A commit with zero size ends in commit error.
- R6: Ways codes 0 to 3 (1, 2, 4 and 8 ways) are always legal. Code 4 (16 ways) is legal only with 16-way support. Codes 8, 9 and 10 (3, 6 and 12 ways) are legal only with 3/6/12-way support. Every other ways code is illegal, and so is any granularity code above 6. An illegal code ends the commit in error.
- R7: In an endpoint bank, a size that is not a multiple of the way count ends the commit in error.
- R8: A commit of decoder i > 0 ends in error if decoder i-1 is not committed when the delay expires.
- R9: Writing the control word with commit request 0 clears committed and error on that edge.
- R10: While a decoder is committed with lock set, writes to all of its registers are ignored. Only reset leaves this state.
- R11: Committed and error are never both set. `dec_committed` and `dec_error` mirror the status bits of each decoder.
- R12: The extra register (skip or target list) stores and reads back both 32-bit halves unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Word address shared by reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| dec_committed | output | NUM_DEC | Committed flag per decoder |
| dec_error | output | NUM_DEC | Commit-error flag per decoder |

## Verification
Results fall due at different times:
- A register write lands on the edge that samples it.
- Read data appears one edge after `rd_en`.
- A decommit clears status on the write edge itself.
- Commit status comes exactly `COMMIT_LAT` edges after the write edge.

The bench drives inputs on falling edges and samples on the falling edge after the edge a result is due on. For every commit it samples the status on each of the `COMMIT_LAT` intervening falling edges, so a result that arrives early or late is caught. The ways and granularity codes are swept over all sixteen values each, and the expected legality is computed from the capability settings.

// File: rtl/mdb_pkg.sv
package mdb_pkg;

  localparam int CTRL_LOCK_BIT   = 8;
  localparam int CTRL_COMMIT_BIT = 9;
  localparam int CTRL_DONE_BIT   = 10;
  localparam int CTRL_ERR_BIT    = 11;
  localparam int CTRL_HOST_BIT   = 12;
  localparam int GRAN_MAX_CODE   = 6;

  typedef enum logic [2:0] {
    OFF_BASE_LO  = 3'd0,
    OFF_BASE_HI  = 3'd1,
    OFF_SIZE_LO  = 3'd2,
    OFF_SIZE_HI  = 3'd3,
    OFF_CTRL     = 3'd4,
    OFF_EXTRA_LO = 3'd5,
    OFF_EXTRA_HI = 3'd6
  } reg_off_e;

  function automatic logic ways_legal(input logic [3:0] code, input logic w3, input logic w16);
    case (code)
      4'd0, 4'd1, 4'd2, 4'd3: return 1'b1;
      4'd4:                   return w16;
      4'd8, 4'd9, 4'd10:      return w3;
      default:                return 1'b0;
    endcase
  endfunction

  function automatic logic size_divides(input logic [63:0] sz, input logic [3:0] code);
    logic [63:0] low_mask;
    if (code[3]) begin
      low_mask = (64'd1 << code[1:0]) - 64'd1;
      return ((sz & low_mask) == 64'd0) && ((sz % 64'd3) == 64'd0);
    end
    low_mask = (64'd1 << code[2:0]) - 64'd1;
    return (sz & low_mask) == 64'd0;
  endfunction

endpackage

// File: rtl/mdb_addr_dec.sv
module mdb_addr_dec #(
  parameter int NUM_DEC = 4,
  parameter int ADDR_W  = 8
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic               cap_hit,
  output logic [NUM_DEC-1:0] dec_hit,
  output logic [2:0]         off
);
  localparam int FIRST = 8;
  localparam int SPAN  = 8;

  assign cap_hit = (addr == '0);
  assign off     = addr[2:0];

  for (genvar i = 0; i < NUM_DEC; i++) begin : g_hit
    localparam int LO = FIRST + SPAN * i;
    localparam int HI = LO + SPAN;
    assign dec_hit[i] = (addr >= ADDR_W'(LO)) && (addr < ADDR_W'(HI)) && (addr[2:0] != 3'd7);
  end
endmodule

// File: rtl/mdb_slot.sv
module mdb_slot
  import mdb_pkg::*;
#(
  parameter int IDX        = 0,
  parameter int COMMIT_LAT = 5,
  parameter int IS_SWITCH  = 0,
  parameter int CAP_W3     = 1,
  parameter int CAP_W16    = 0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [2:0]  off,
  input  logic [31:0] wdata,
  input  logic        prev_committed,
  output logic [31:0] rd_word,
  output logic        committed,
  output logic        commit_err
);
  localparam int CNT_W = $clog2(COMMIT_LAT + 1);

  logic [63:0]      base_q, size_q, extra_q;
  logic [3:0]       gran_q, ways_q;
  logic             lock_q, host_q, req_q, busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic             locked, cfg_ok, div_ok;

  assign locked = committed && lock_q;

  if (IS_SWITCH != 0) begin : g_switch
    assign div_ok = 1'b1;
  end else begin : g_endpoint
    assign div_ok = size_divides(size_q, ways_q);
  end

  always_comb begin
    cfg_ok = (size_q != 64'd0)
          && ways_legal(ways_q, CAP_W3 != 0, CAP_W16 != 0)
          && (gran_q <= 4'(GRAN_MAX_CODE))
          && div_ok
          && prev_committed;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q     <= '0;
      size_q     <= '0;
      extra_q    <= '0;
      gran_q     <= '0;
      ways_q     <= '0;
      lock_q     <= 1'b0;
      host_q     <= 1'b0;
      req_q      <= 1'b0;
      busy_q     <= 1'b0;
      cnt_q      <= '0;
      committed  <= 1'b0;
      commit_err <= 1'b0;
    end else begin
      if (busy_q) begin
        if (cnt_q == CNT_W'(COMMIT_LAT - 1)) begin
          busy_q     <= 1'b0;
          committed  <= cfg_ok;
          commit_err <= !cfg_ok;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
      if (wr_en && !locked) begin
        case (off)
          OFF_BASE_LO:  base_q[31:0]   <= wdata;
          OFF_BASE_HI:  base_q[63:32]  <= wdata;
          OFF_SIZE_LO:  size_q[31:0]   <= wdata;
          OFF_SIZE_HI:  size_q[63:32]  <= wdata;
          OFF_EXTRA_LO: extra_q[31:0]  <= wdata;
          OFF_EXTRA_HI: extra_q[63:32] <= wdata;
          OFF_CTRL: begin
            gran_q <= wdata[3:0];
            ways_q <= wdata[7:4];
            lock_q <= wdata[CTRL_LOCK_BIT];
            host_q <= wdata[CTRL_HOST_BIT];
            req_q  <= wdata[CTRL_COMMIT_BIT];
            if (wdata[CTRL_COMMIT_BIT] && !req_q) begin
              busy_q     <= 1'b1;
              cnt_q      <= '0;
              committed  <= 1'b0;
              commit_err <= 1'b0;
            end else if (!wdata[CTRL_COMMIT_BIT]) begin
              busy_q     <= 1'b0;
              cnt_q      <= '0;
              committed  <= 1'b0;
              commit_err <= 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (off)
      OFF_BASE_LO:  rd_word = base_q[31:0];
      OFF_BASE_HI:  rd_word = base_q[63:32];
      OFF_SIZE_LO:  rd_word = size_q[31:0];
      OFF_SIZE_HI:  rd_word = size_q[63:32];
      OFF_EXTRA_LO: rd_word = extra_q[31:0];
      OFF_EXTRA_HI: rd_word = extra_q[63:32];
      OFF_CTRL:     rd_word = {19'd0, host_q, commit_err, committed, req_q, lock_q, ways_q, gran_q};
      default:      rd_word = '0;
    endcase
  end

  assert_status_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
    !(committed && commit_err));

  assert_lock_freeze_R10: assert property (@(posedge clk) disable iff (rst)
    (committed && lock_q) |=> ($stable(base_q) && $stable(size_q) && $stable(extra_q) && committed));

  assert_size_nonzero_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(committed) |-> ($past(size_q) != 64'd0));

  assert_delay_bound_R4: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (cnt_q < CNT_W'(COMMIT_LAT)));

  if (IDX > 0) begin : g_order_chk
    assert_in_order_R8: assert property (@(posedge clk) disable iff (rst)
      $rose(committed) |-> $past(prev_committed));
  end
endmodule

// File: rtl/mem_decoder_bank.sv
module mem_decoder_bank #(
  parameter int NUM_DEC     = 4,
  parameter int ADDR_W      = 8,
  parameter int COMMIT_LAT  = 5,
  parameter int IS_SWITCH   = 0,
  parameter int TARGET_CNT  = 8,
  parameter int CAP_ILV_LO  = 1,
  parameter int CAP_ILV_HI  = 0,
  parameter int CAP_W3      = 1,
  parameter int CAP_W16     = 0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [31:0]        wdata,
  output logic [31:0]        rdata,
  output logic [NUM_DEC-1:0] dec_committed,
  output logic [NUM_DEC-1:0] dec_error
);
  localparam logic [31:0] CAP_WORD =
      32'(NUM_DEC % 16)
    | (32'(TARGET_CNT % 16) << 4)
    | (32'(CAP_ILV_LO != 0) << 8)
    | (32'(CAP_ILV_HI != 0) << 9)
    | (32'(CAP_W3 != 0) << 10)
    | (32'(CAP_W16 != 0) << 11);

  logic               cap_hit;
  logic [NUM_DEC-1:0] dec_hit;
  logic [2:0]         off;
  logic [31:0]        rd_words [NUM_DEC];
  logic [31:0]        rd_mux;

  mdb_addr_dec #(.NUM_DEC(NUM_DEC), .ADDR_W(ADDR_W)) u_dec (
    .addr(addr), .cap_hit(cap_hit), .dec_hit(dec_hit), .off(off)
  );

  for (genvar i = 0; i < NUM_DEC; i++) begin : g_slot
    logic prev;
    if (i == 0) begin : g_first
      assign prev = 1'b1;
    end else begin : g_next
      assign prev = dec_committed[i-1];
    end
    mdb_slot #(
      .IDX(i), .COMMIT_LAT(COMMIT_LAT), .IS_SWITCH(IS_SWITCH),
      .CAP_W3(CAP_W3), .CAP_W16(CAP_W16)
    ) u_slot (
      .clk(clk), .rst(rst),
      .wr_en(wr_en && dec_hit[i]),
      .off(off), .wdata(wdata),
      .prev_committed(prev),
      .rd_word(rd_words[i]),
      .committed(dec_committed[i]),
      .commit_err(dec_error[i])
    );
  end

  always_comb begin
    rd_mux = cap_hit ? CAP_WORD : 32'd0;
    for (int i = 0; i < NUM_DEC; i++) begin
      if (dec_hit[i]) rd_mux = rd_mux | rd_words[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  assert_single_target_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cap_hit, dec_hit}));
endmodule

// File: tb/sim_mem_decoder_bank.sv
`timescale 1ns/1ps
module sim_mem_decoder_bank;
  localparam int N   = 4;
  localparam int LAT = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [N-1:0] dec_committed, dec_error;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mem_decoder_bank #(.NUM_DEC(N), .COMMIT_LAT(LAT)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .dec_committed(dec_committed), .dec_error(dec_error)
  );

  function automatic int adr(input int i, input int o);
    return 8 + 8 * i + o;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = 8'(a); wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    @(negedge clk); rd_en = 1'b1; addr = 8'(a);
    @(negedge clk); rd_en = 1'b0; v = rdata;
  endtask

  // Commit decoder i with the given control fields, check status on every cycle.
  task automatic commit(input int i, input logic [31:0] ctl, input bit ok, input string req, input bit keep);
    logic [31:0] v;
    wr(adr(i, 4), ctl | 32'h200);
    for (int k = 1; k <= LAT; k++) begin
      @(negedge clk);
      check({req, " committed"}, 32'(dec_committed[i]), 32'(k == LAT && ok));
      check({req, " error"}, 32'(dec_error[i]), 32'(k == LAT && !ok));
    end
    rd(adr(i, 4), v);
    check({req, " ctrl readback R4"}, v, ctl | 32'h200 | (ok ? 32'h400 : 32'h800));
    if (!keep) begin
      wr(adr(i, 4), ctl);
      check("R9 decommit clears status", {30'd0, dec_committed[i], dec_error[i]}, 32'd0);
    end
  endtask

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    check("R1 status", {dec_committed, dec_error}, '0);
    for (int i = 0; i < N; i++)
      for (int o = 0; o < 7; o++) begin
        rd(adr(i, o), v);
        check("R1 register zero", v, 32'd0);
      end

    // R3: capability word (4 decoders, 8 targets, ilv 11:8, 3/6/12-way)
    rd(0, v);
    check("R3 capability", v, 32'h0000_0584);
    rd(adr(0, 7), v);
    check("R2 unmapped word", v, 32'd0);

    // R2 / R12: read-write sweep
    for (int i = 0; i < N; i++)
      for (int o = 0; o < 7; o++)
        if (o != 4) wr(adr(i, o), 32'hA500_0000 | 32'(i << 8) | 32'(o));
    for (int i = 0; i < N; i++)
      for (int o = 0; o < 7; o++)
        if (o != 4) begin
          rd(adr(i, o), v);
          check((o >= 5) ? "R12 extra readback" : "R2 readback", v, 32'hA500_0000 | 32'(i << 8) | 32'(o));
        end

    // Size 0x3000 divides by every supported way count
    wr(adr(0, 2), 32'h3000); wr(adr(0, 3), 32'h0);

    // R6: ways sweep
    for (int w = 0; w < 16; w++)
      commit(0, 32'(w << 4), (w <= 3) || (w >= 8 && w <= 10), "R6 ways", 1'b0);
    // R6: granularity sweep
    for (int g = 0; g < 16; g++)
      commit(0, 32'(g), g <= 6, "R6 gran", 1'b0);

    // R5: zero size
    wr(adr(0, 2), 32'h0);
    commit(0, 32'h0, 1'b0, "R5 zero size", 1'b0);

    // R7: divisibility
    wr(adr(0, 2), 32'h1000);
    commit(0, 32'h80, 1'b0, "R7 3-way not divisible", 1'b0);
    wr(adr(0, 2), 32'h1002);
    commit(0, 32'h20, 1'b0, "R7 4-way not divisible", 1'b0);
    commit(0, 32'h10, 1'b1, "R7 2-way divisible", 1'b0);
    commit(0, 32'h00, 1'b1, "R4 1-way", 1'b0);

    // R8: in-order commit
    wr(adr(1, 2), 32'h1000); wr(adr(1, 3), 32'h0);
    commit(1, 32'h0, 1'b0, "R8 out of order", 1'b0);
    commit(0, 32'h0, 1'b1, "R8 first", 1'b1);
    commit(1, 32'h0, 1'b1, "R8 second", 1'b0);
    wr(adr(0, 4), 32'h0);
    check("R9 decoder0 decommit", {30'd0, dec_committed[0], dec_error[0]}, 32'd0);

    // R10: lock
    commit(0, 32'h100, 1'b1, "R10 locked commit", 1'b1);
    wr(adr(0, 0), 32'h1234);
    wr(adr(0, 4), 32'h0);
    wr(adr(0, 5), 32'hFFFF);
    rd(adr(0, 0), v); check("R10 base ignored", v, 32'hA500_0000);
    rd(adr(0, 5), v); check("R10 extra ignored", v, 32'hA500_0005);
    rd(adr(0, 2), v); check("R10 size ignored", v, 32'h1002);
    check("R10 still committed", 32'(dec_committed[0]), 32'd1);

    // R1: reset releases lock
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 status after reset", {dec_committed, dec_error}, '0);
    rd(adr(0, 4), v); check("R1 ctrl after reset", v, 32'd0);
    rd(adr(0, 0), v); check("R1 base after reset", v, 32'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule